// File: doc/BRIEF.md
# Indexed Palette Write Port

This block holds a 256-entry colour lookup table in which every entry carries an 8-bit red, green and blue value. Software loads it through two bus registers. The index register chooses the entry that the next colour byte lands in. The colour data register takes component bytes in a fixed red, green, blue rotation. Once a triple is complete, the index steps to the next entry on its own, so the whole table can be loaded after one index write.

A colour data write is either one byte wide or 32 bits wide. A 32-bit write carries four consecutive component bytes, and the most significant byte is used first. Those four bytes can run across the end of one entry into the next. Every colour data write raises a one-cycle repaint request, which the display side uses to redraw the whole screen. Scan-out logic reads entries through a combinational lookup port that does not disturb the write sequencer. Bus reads of either palette register return zero.

Top module: `pal_write_port`

## Requirements
- R1: A bus write to offset 0 loads the entry index from bus_wdata[7:0] and forces the component phase back to red, even when a triple is only partly written.
- R2: A one-byte write (bus_wide=0) to offset 4 stores bus_wdata[7:0] in the current component of the current entry. bits 31:8 are ignored. Successive bytes go to red, then green, then blue.
- R3: After the blue byte is stored, the index increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R4: A 32-bit write (bus_wide=1) to offset 4 supplies four component bytes in the order bits 31:24, 23:16, 15:8, 7:0. Each byte advances the phase, and the bytes may cross into the next entry.
- R5: bus_rdata is zero for every address.
- R6: Reset clears all 256 red, green and blue values to zero, sets the index to 0 and sets the phase to red.
- R7: repaint_o is high for exactly the one cycle after each colour data write. Index writes and other writes leave it low.
- R8: The lookup port returns {red, green, blue} of entry lk_idx combinationally. Changing lk_idx does not alter the index or the phase.
- R9: Bus writes to any offset other than 0 or 4 change no entry, no index, no phase and no repaint flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 3 | Byte offset of the access |
| bus_wide | input | 1 | 1: 32-bit write, 0: one-byte write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (always zero) |
| lk_idx | input | 8 | Lookup entry index |
| lk_red | output | 8 | Red value of the looked-up entry |
| lk_grn | output | 8 | Green value of the looked-up entry |
| lk_blu | output | 8 | Blue value of the looked-up entry |
| repaint_o | output | 1 | One-cycle full-repaint request |

## Verification
A full byte-by-byte load of all 256 entries with a distinct value per component shows whether any byte lands in the wrong component or the wrong entry. The byte after that load shows the 255-to-0 wrap. A run of 32-bit writes that starts at the green phase near entry 250 and runs across the wrap separates correct most-significant-first ordering and carry into the next entry from a lane-swapped or non-carrying design. Three further patterns are mixed in: an index write in the middle of a triple, writes to unused offsets with garbage data, and a lookup sweep between writes. Each is followed by the next expected byte placement, which reveals any hidden change to the phase or index.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2,
    PH_BAD = 2'd3
  } phase_e;

  localparam int NCOMP = 3;
endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LANES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_idx,
  input  logic [IDX_W-1:0]                ld_val,
  input  logic                            push,
  input  logic                            wide,
  output logic [LANES-1:0]                lane_vld,
  output logic [LANES-1:0][IDX_W-1:0]     lane_idx,
  output logic [LANES-1:0][1:0]           lane_comp
);
  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             en;

  // next-state: lane targets and the post-write index/phase
  always_comb begin
    int p0;
    int t;
    int tend;
    // an illegal phase code is taken as red
    p0 = (phase_q == PH_BAD) ? 0 : int'(phase_q);
    for (int k = 0; k < LANES; k++) begin
      t            = p0 + k;
      lane_comp[k] = 2'(t % NCOMP);
      lane_idx[k]  = idx_q + IDX_W'(t / NCOMP);
      lane_vld[k]  = push && (wide || (k == 0));
    end
    tend = p0 + (wide ? LANES : 1);
    en   = ld_idx | push;
    if (ld_idx) begin
      idx_d   = ld_val;
      phase_d = PH_RED;
    end else begin
      idx_d   = idx_q + IDX_W'(tend / NCOMP);
      phase_d = phase_e'(2'(tend % NCOMP));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (en) begin
      idx_q   <= idx_d;
      phase_q <= phase_d;
    end
  end

  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_idx |=> (idx_q == $past(ld_val)) && (phase_q == PH_RED));

  p_byte_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !wide && !ld_idx && phase_q == PH_RED) |=>
      (phase_q == PH_GRN) && $stable(idx_q));

  p_blue_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !wide && !ld_idx && phase_q == PH_BLU) |=>
      (phase_q == PH_RED) && (idx_q == $past(idx_q) + 1'b1));

  p_word_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && wide && !ld_idx && phase_q == PH_RED) |=>
      (phase_q == phase_e'(2'(LANES % NCOMP))) &&
      (idx_q == $past(idx_q) + IDX_W'(LANES / NCOMP)));

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != PH_BAD);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_idx && !push) |=> $stable(idx_q) && $stable(phase_q));
endmodule

// File: rtl/pal_table.sv
module pal_table
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 8,
  parameter int LANES   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0]              lane_vld,
  input  logic [LANES-1:0][IDX_W-1:0]   lane_idx,
  input  logic [LANES-1:0][1:0]         lane_comp,
  input  logic [LANES-1:0][COMP_W-1:0]  lane_data,
  input  logic [IDX_W-1:0]              lk_idx,
  output logic [COMP_W-1:0]             lk_red,
  output logic [COMP_W-1:0]             lk_grn,
  output logic [COMP_W-1:0]             lk_blu
);
  localparam int SLOT_W = NCOMP * COMP_W;

  logic [ENTRIES*SLOT_W-1:0] flat;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    for (genvar c = 0; c < NCOMP; c++) begin : g_comp
      logic              we;
      logic [COMP_W-1:0] wd, q;

      always_comb begin
        we = 1'b0;
        wd = q;
        for (int k = 0; k < LANES; k++) begin
          if (lane_vld[k] && lane_idx[k] == IDX_W'(e) && lane_comp[k] == 2'(c)) begin
            we = 1'b1;
            wd = lane_data[k];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wd;
      end

      assign flat[(e*NCOMP+c)*COMP_W +: COMP_W] = q;
    end
  end

  // component order inside a slot: red, green, blue
  assign lk_red = flat[(int'(lk_idx)*NCOMP+0)*COMP_W +: COMP_W];
  assign lk_grn = flat[(int'(lk_idx)*NCOMP+1)*COMP_W +: COMP_W];
  assign lk_blu = flat[(int'(lk_idx)*NCOMP+2)*COMP_W +: COMP_W];

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    p_lane_comp_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lane_vld[k] |-> (lane_comp[k] != 2'd3));
  end

  for (genvar k = 1; k < LANES; k++) begin : g_lane_seq_chk
    p_lane_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_vld[k] |-> lane_vld[k-1] &&
        ((lane_comp[k-1] == 2'd2) ? (lane_comp[k] == 2'd0 && lane_idx[k] == lane_idx[k-1] + 1'b1)
                                  : (lane_comp[k] == lane_comp[k-1] + 1'b1 && lane_idx[k] == lane_idx[k-1])));
  end
endmodule

// File: rtl/pal_write_port.sv
module pal_write_port
  import pal_pkg::*;
#(
  parameter int ENTRIES  = 256,
  parameter int COMP_W   = 8,
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 3,
  parameter int OFF_IDX  = 0,
  parameter int OFF_DATA = 4
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wide,
  input  logic [BUS_W-1:0]         bus_wdata,
  output logic [BUS_W-1:0]         bus_rdata,
  input  logic [$clog2(ENTRIES)-1:0] lk_idx,
  output logic [COMP_W-1:0]        lk_red,
  output logic [COMP_W-1:0]        lk_grn,
  output logic [COMP_W-1:0]        lk_blu,
  output logic                     repaint_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int LANES = BUS_W / COMP_W;

  logic                         rst_n;
  logic                         hit_idx, hit_dat;
  logic [LANES-1:0]             lane_vld;
  logic [LANES-1:0][IDX_W-1:0]  lane_idx;
  logic [LANES-1:0][1:0]        lane_comp;
  logic [LANES-1:0][COMP_W-1:0] lane_data;
  logic                         repaint_d, repaint_q;

  pal_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign hit_idx = bus_wr && (bus_addr == ADDR_W'(OFF_IDX));
  assign hit_dat = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));

  // lane 0 is the first byte used: top byte when wide, low byte otherwise
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_first
      assign lane_data[k] = bus_wide ? bus_wdata[BUS_W-1 -: COMP_W] : bus_wdata[COMP_W-1:0];
    end else begin : g_rest
      assign lane_data[k] = bus_wdata[BUS_W-1-k*COMP_W -: COMP_W];
    end
  end

  pal_seq #(
    .IDX_W (IDX_W),
    .LANES (LANES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_idx    (hit_idx),
    .ld_val    (bus_wdata[IDX_W-1:0]),
    .push      (hit_dat),
    .wide      (bus_wide),
    .lane_vld  (lane_vld),
    .lane_idx  (lane_idx),
    .lane_comp (lane_comp)
  );

  pal_table #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .COMP_W  (COMP_W),
    .LANES   (LANES)
  ) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_vld  (lane_vld),
    .lane_idx  (lane_idx),
    .lane_comp (lane_comp),
    .lane_data (lane_data),
    .lk_idx    (lk_idx),
    .lk_red    (lk_red),
    .lk_grn    (lk_grn),
    .lk_blu    (lk_blu)
  );

  always_comb repaint_d = hit_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) repaint_q <= 1'b0;
    else        repaint_q <= repaint_d;
  end

  assign repaint_o = repaint_q;
  assign bus_rdata = '0;

  p_repaint_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_DATA)) |=> repaint_o);

  p_repaint_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(OFF_DATA)) |=> !repaint_o);
endmodule

// File: tb/pal_write_port_tb_top.sv
`timescale 1ns/1ps
module pal_write_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic        bus_wide;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  lk_idx;
  logic [7:0]  lk_red, lk_grn, lk_blu;
  logic        repaint_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] er [256];
  logic [7:0] eg [256];
  logic [7:0] eb [256];
  int m_idx, m_ph;

  pal_write_port dut_i (
    .clk (clk), .rst_ni (rst_ni), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wide (bus_wide), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .lk_idx (lk_idx), .lk_red (lk_red), .lk_grn (lk_grn), .lk_blu (lk_blu),
    .repaint_o (repaint_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int e = 0; e < 256; e++) begin er[e] = 0; eg[e] = 0; eb[e] = 0; end
    m_idx = 0; m_ph = 0;
  endtask

  task automatic model_byte(input logic [7:0] b);
    case (m_ph)
      0: er[m_idx] = b;
      1: eg[m_idx] = b;
      default: eb[m_idx] = b;
    endcase
    if (m_ph == 2) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
    else m_ph++;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  task automatic bus_write(input logic [2:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wide = w; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic wr_index(input logic [7:0] v);
    bus_write(3'd0, 1'b0, {24'hC3A5F0, v});
    chk("R7 index write no repaint", {31'd0, repaint_o}, 32'd0);
    m_idx = v; m_ph = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    bus_write(3'd4, 1'b0, {24'h9E3B71, b});
    chk("R7 byte write repaint", {31'd0, repaint_o}, 32'd1);
    model_byte(b);
  endtask

  task automatic wr_word(input logic [31:0] w);
    bus_write(3'd4, 1'b1, w);
    chk("R7 word write repaint", {31'd0, repaint_o}, 32'd1);
    model_byte(w[31:24]); model_byte(w[23:16]); model_byte(w[15:8]); model_byte(w[7:0]);
  endtask

  task automatic check_all(input string req);
    for (int e = 0; e < 256; e++) begin
      lk_idx = 8'(e);
      #1;
      chk(req, {8'd0, lk_red, lk_grn, lk_blu}, {8'd0, er[e], eg[e], eb[e]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bus_wr = 0; bus_addr = 0; bus_wide = 0; bus_wdata = 0; lk_idx = 0;
    do_reset();

    // R6 reset state, R5 reads
    check_all("R6 reset clear");
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a); #1;
      chk("R5 read zero", bus_rdata, 32'd0);
    end
    chk("R7 idle repaint low", {31'd0, repaint_o}, 32'd0);

    // R6: index 0 and red phase after reset, no index write needed
    wr_byte(8'h11);
    check_all("R6 first byte to entry0 red");

    // R2/R3: full byte sweep, then wrap
    wr_index(8'd0);
    for (int e = 0; e < 256; e++)
      for (int c = 0; c < 3; c++)
        wr_byte(8'((e * 7 + c * 61 + 3) & 255));
    check_all("R2 byte sweep");
    wr_byte(8'hE7);
    check_all("R3 wrap 255 to 0");

    // R4: word writes from green phase across wrap
    wr_index(8'd250);
    wr_byte(8'h5C);
    for (int i = 0; i < 20; i++)
      wr_word(32'((i * 32'h01030507) ^ 32'hA1B2C3D4));
    check_all("R4 word writes");
    wr_byte(8'h77);
    check_all("R4 phase after words");

    // R1: index write mid triple
    wr_index(8'd7);
    wr_byte(8'h21); wr_byte(8'h22);
    wr_index(8'd9);
    wr_byte(8'h31);
    check_all("R1 index reload mid triple");

    // R9: other offsets ignored
    wr_byte(8'h41);
    for (int a = 1; a < 8; a++) begin
      if (a != 4) begin
        bus_write(3'(a), 1'b1, 32'hDEADBEEF);
        chk("R9 ignored write no repaint", {31'd0, repaint_o}, 32'd0);
      end
    end
    wr_byte(8'h42);
    check_all("R9 ignored offsets");

    // R8: lookup sweep does not disturb the sequencer
    for (int e = 255; e >= 0; e--) begin lk_idx = 8'(e); #1; end
    wr_word(32'h0102_0304);
    check_all("R8 lookup no side effect");

    // R6: reset in the middle of a triple
    wr_byte(8'h99);
    do_reset();
    check_all("R6 reset mid sequence");
    wr_byte(8'h5A);
    check_all("R6 phase red after reset");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule